// File: doc/BRIEF.md
# Dual-Channel Compare Waveform Output Stage

This block turns the compare-match strobes of a timer counter into two waveform pin levels, channel A and channel B. For each channel it decides whether the timer owns the pin and, if so, which level the pin carries. It takes the counter's present direction as an input. With the channel's PWM enable set, the set or clear action of a match depends on that direction. This gives symmetric, phase-correct waveforms from an up/down counter.

Each channel has a two-bit output-mode field and a PWM enable. Channel A reads both from the main timer control register, and channel B reads them from the general control register. The modes are: 0 = pin released, 1 = toggle, 2 = clear, 3 = set. Writing the general control register can also force a compare on either channel. A force applies the non-PWM action at once, without a counter match. The force bits are write-only strobes, so the readback path always shows them as zero. Compare flags, interrupt logic and the port register itself sit in neighbouring blocks.

Top module: `ocu_dual`

## Requirements
- R1: While reset is asserted and after it is released, with no events, both pin levels are 0. With mode fields of 0, both override enables are 0.
- R2: A channel's override enable is 1 exactly when its mode field is nonzero. Channel A's mode field is main_ctl_i[5:4] and channel B's is gen_ctl_i[5:4].
- R3: With the channel's PWM enable clear (A: main_ctl_i[6], B: gen_ctl_i[6]) and mode 1, a match inverts the pin level at the clock edge that samples the match.
- R4: With PWM clear, a match in mode 2 makes the level 0 and a match in mode 3 makes it 1, at the sampling edge.
- R5: In mode 0 a match or force leaves the pin level unchanged, and the override enable stays 0.
- R6: With PWM set, in mode 2 a match while count_up_i=1 gives level 0 and a match while count_up_i=0 gives level 1. Mode 3 gives the opposite levels.
- R7: With PWM set and mode 1, a match inverts the level.
- R8: A force strobe applies the non-PWM action of R3/R4 to its channel at the next edge, without any match. The force strobe for A is gen_ctl_i[2] and for B is gen_ctl_i[3], both qualified by gen_ctl_we_i=1.
- R9: A force strobe has no effect on a channel whose PWM enable is set or whose mode is 0.
- R10: A match and a force on the same channel in the same cycle apply the action once. In mode 1 the level therefore inverts exactly once.
- R11: Force bits present while gen_ctl_we_i=0 have no effect. gen_ctl_rd_o equals gen_ctl_i with bits 3 and 2 forced to 0.
- R12: Events on one channel never change the other channel's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ctl_i | input | 8 | Main timer control register value (A mode in 5:4, A PWM in 6) |
| gen_ctl_i | input | 8 | General control register value or write data (B mode 5:4, B PWM 6, force A bit 2, force B bit 3) |
| gen_ctl_we_i | input | 1 | Write strobe of the general control register; qualifies the force bits |
| gen_ctl_rd_o | output | 8 | Readback of the general control register with force bits zeroed |
| match_a_i | input | 1 | Counter matched compare value A this cycle |
| match_b_i | input | 1 | Counter matched compare value B this cycle |
| count_up_i | input | 1 | Counter direction: 1 up, 0 down |
| pin_a_en_o | output | 1 | Timer owns pin A |
| pin_a_val_o | output | 1 | Level for pin A |
| pin_b_en_o | output | 1 | Timer owns pin B |
| pin_b_val_o | output | 1 | Level for pin B |

## Verification
Matches are applied in every mode with PWM clear and with PWM set. In PWM mode the counter direction is switched between matches, so a direction-dependent action can be told apart from a plain set or clear. Each test starts from a level opposite to the expected result where possible, so that a missing action is visible. Force strobes are sent with and without the write strobe, in PWM and in mode 0, and together with a real match in toggle mode. This separates a correct single action from a double toggle that cancels itself. Events on one channel are followed by a check of the other channel's level.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  localparam int NUM_CH      = 2;
  localparam int CTL_W       = 8;
  localparam int MODE_LSB    = 4;
  localparam int PWM_BIT     = 6;
  localparam int FRC_LSB     = 2;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_CLEAR  = 2'd2,
    OM_SET    = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic      pwm;
    out_mode_e mode;
  } ch_cfg_t;

  // Whether a channel acts this cycle: a real match always counts,
  // a force only outside PWM; mode OFF never acts.
  function automatic logic ch_fires(ch_cfg_t cfg, logic match, logic frc);
    return (cfg.mode != OM_OFF) && (match || (frc && !cfg.pwm));
  endfunction

  // Level after an action, given the mode, the PWM enable and direction.
  function automatic logic ch_next(ch_cfg_t cfg, logic up, logic cur);
    logic nxt;
    unique case (cfg.mode)
      OM_TOGGLE: nxt = ~cur;
      OM_CLEAR:  nxt = cfg.pwm ? ~up : 1'b0;
      OM_SET:    nxt = cfg.pwm ?  up : 1'b1;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ocu_ctl_decode.sv
module ocu_ctl_decode
  import ocu_pkg::*;
(
  input  logic [CTL_W-1:0]          main_ctl_i,
  input  logic [CTL_W-1:0]          gen_ctl_i,
  input  logic                      gen_ctl_we_i,
  output ch_cfg_t [NUM_CH-1:0]      cfg_o,
  output logic    [NUM_CH-1:0]      frc_o,
  output logic    [CTL_W-1:0]       gen_rd_o
);

  localparam logic [CTL_W-1:0] FRC_MASK = CTL_W'(((1 << NUM_CH) - 1) << FRC_LSB);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CTL_W-1:0] src;
    if (ch == 0) begin : g_main
      assign src = main_ctl_i;
    end else begin : g_gen
      assign src = gen_ctl_i;
    end
    assign cfg_o[ch].pwm  = src[PWM_BIT];
    assign cfg_o[ch].mode = out_mode_e'(src[MODE_LSB +: 2]);
    assign frc_o[ch]      = gen_ctl_we_i && gen_ctl_i[FRC_LSB + ch];
  end

  assign gen_rd_o = gen_ctl_i & ~FRC_MASK;

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_cfg_t cfg_i,
  input  logic    match_i,
  input  logic    frc_i,
  input  logic    count_up_i,
  output logic    fire_o,
  output logic    pin_en_o,
  output logic    pin_val_o
);

  logic lvl_q;

  assign fire_o   = ch_fires(cfg_i, match_i, frc_i);
  assign pin_en_o = (cfg_i.mode != OM_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (fire_o) begin
      lvl_q <= ch_next(cfg_i, count_up_i, lvl_q);
    end
  end

  assign pin_val_o = lvl_q;

endmodule

// File: rtl/ocu_dual.sv
module ocu_dual
  import ocu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       main_ctl_i,
  input  logic [7:0]       gen_ctl_i,
  input  logic             gen_ctl_we_i,
  output logic [7:0]       gen_ctl_rd_o,
  input  logic             match_a_i,
  input  logic             match_b_i,
  input  logic             count_up_i,
  output logic             pin_a_en_o,
  output logic             pin_a_val_o,
  output logic             pin_b_en_o,
  output logic             pin_b_val_o
);

  ch_cfg_t [NUM_CH-1:0] cfg_w;
  logic    [NUM_CH-1:0] frc_w;
  logic    [NUM_CH-1:0] match_w;
  logic    [NUM_CH-1:0] fire_w;
  logic    [NUM_CH-1:0] en_w;
  logic    [NUM_CH-1:0] val_w;

  assign match_w = {match_b_i, match_a_i};

  ocu_ctl_decode u_dec (
    .main_ctl_i   (main_ctl_i),
    .gen_ctl_i    (gen_ctl_i),
    .gen_ctl_we_i (gen_ctl_we_i),
    .cfg_o        (cfg_w),
    .frc_o        (frc_w),
    .gen_rd_o     (gen_ctl_rd_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    ocu_channel u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (cfg_w[ch]),
      .match_i    (match_w[ch]),
      .frc_i      (frc_w[ch]),
      .count_up_i (count_up_i),
      .fire_o     (fire_w[ch]),
      .pin_en_o   (en_w[ch]),
      .pin_val_o  (val_w[ch])
    );
  end

  assign pin_a_en_o  = en_w[0];
  assign pin_a_val_o = val_w[0];
  assign pin_b_en_o  = en_w[1];
  assign pin_b_val_o = val_w[1];

endmodule

// File: rtl/ocu_dual_chk.sv
module ocu_dual_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] main_ctl_i,
  input logic [7:0] gen_ctl_i,
  input logic       match_a_i,
  input logic       match_b_i,
  input logic       count_up_i,
  input logic       frc_a,
  input logic       frc_b,
  input logic       pin_a_val_o,
  input logic       pin_b_val_o
);

  // R12: without an event of its own a channel's level holds
  p_hold_a_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_a_i && !frc_a) |=> $stable(pin_a_val_o));
  p_hold_b_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_b_i && !frc_b) |=> $stable(pin_b_val_o));

  // R5: mode 0 never changes the level
  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ctl_i[5:4] == 2'd0) |=> $stable(pin_a_val_o));

  // R3: non-PWM toggle
  p_tog_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && !main_ctl_i[6] && main_ctl_i[5:4] == 2'd1)
      |=> (pin_a_val_o != $past(pin_a_val_o)));

  // R4: non-PWM clear and set
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && !main_ctl_i[6] && main_ctl_i[5:4] == 2'd2) |=> !pin_a_val_o);
  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && !main_ctl_i[6] && main_ctl_i[5:4] == 2'd3) |=> pin_a_val_o);

  // R6: PWM clear mode follows direction
  p_pwm_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && main_ctl_i[6] && main_ctl_i[5:4] == 2'd2)
      |=> (pin_a_val_o == !$past(count_up_i)));

  // R9: force is ignored under PWM
  p_frc_pwm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_b && gen_ctl_i[6] && !match_b_i) |=> $stable(pin_b_val_o));

  // R10: match plus force in toggle mode inverts once
  p_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a_i && frc_a && !main_ctl_i[6] && main_ctl_i[5:4] == 2'd1)
      |=> (pin_a_val_o != $past(pin_a_val_o)));

endmodule

bind ocu_dual ocu_dual_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .main_ctl_i  (main_ctl_i),
  .gen_ctl_i   (gen_ctl_i),
  .match_a_i   (match_a_i),
  .match_b_i   (match_b_i),
  .count_up_i  (count_up_i),
  .frc_a       (frc_w[0]),
  .frc_b       (frc_w[1]),
  .pin_a_val_o (pin_a_val_o),
  .pin_b_val_o (pin_b_val_o)
);

// File: tb/ocu_dual_tb.sv
module ocu_dual_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] main_ctl = 8'h00;
  logic [7:0] gen_ctl = 8'h00;
  logic [7:0] gen_base = 8'h00;
  logic       gen_we = 1'b0;
  logic       match_a = 1'b0;
  logic       match_b = 1'b0;
  logic       count_up = 1'b1;
  logic [7:0] gen_rd;
  logic       a_en, a_val, b_en, b_val;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ocu_dual u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_ctl_i   (main_ctl),
    .gen_ctl_i    (gen_ctl),
    .gen_ctl_we_i (gen_we),
    .gen_ctl_rd_o (gen_rd),
    .match_a_i    (match_a),
    .match_b_i    (match_b),
    .count_up_i   (count_up),
    .pin_a_en_o   (a_en),
    .pin_a_val_o  (a_val),
    .pin_b_en_o   (b_en),
    .pin_b_val_o  (b_val)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [7:0] m, input logic [7:0] g);
    @(negedge clk);
    main_ctl = m;
    gen_base = g;
    gen_ctl  = g;
    #1;
  endtask

  // one-cycle event: matches and/or force bits (bit0 = A, bit1 = B)
  task automatic pulse(input logic ma, input logic mb, input logic [1:0] frc, input logic we);
    @(negedge clk);
    match_a = ma;
    match_b = mb;
    gen_ctl = gen_base | {4'b0, frc, 2'b00};
    gen_we  = we;
    @(negedge clk);
    match_a = 1'b0;
    match_b = 1'b0;
    gen_ctl = gen_base;
    gen_we  = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 a_val in reset", a_val, 0);
    chk("R1 b_val in reset", b_val, 0);
    chk("R1 a_en in reset", a_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 a_val after reset", a_val, 0);
    chk("R1 b_val after reset", b_val, 0);
    chk("R1 b_en after reset", b_en, 0);
  endtask

  task automatic t_override;
    set_cfg(8'h10, 8'h20);
    chk("R2 a_en mode1", a_en, 1);
    chk("R2 b_en mode2", b_en, 1);
    set_cfg(8'h00, 8'h30);
    chk("R2 a_en mode0", a_en, 0);
    chk("R2 b_en mode3", b_en, 1);
    set_cfg(8'h00, 8'hFC);
    chk("R11 readback hides force bits", gen_rd, 8'hF0);
    set_cfg(8'h00, 8'h00);
    chk("R2 b_en mode0", b_en, 0);
  endtask

  task automatic t_nonpwm;
    set_cfg(8'h30, 8'h00);
    pulse(1, 0, 2'b00, 0); chk("R4 A set", a_val, 1);
    set_cfg(8'h20, 8'h00);
    pulse(1, 0, 2'b00, 0); chk("R4 A clear", a_val, 0);
    set_cfg(8'h10, 8'h30);
    pulse(1, 0, 2'b00, 0); chk("R3 A toggle 1", a_val, 1);
    pulse(1, 0, 2'b00, 0); chk("R3 A toggle 2", a_val, 0);
    pulse(0, 1, 2'b00, 0); chk("R4 B set", b_val, 1);
    chk("R12 A untouched by B", a_val, 0);
  endtask

  task automatic t_mode0;
    set_cfg(8'h30, 8'h00);
    pulse(1, 0, 2'b00, 0); chk("R4 A set before off", a_val, 1);
    set_cfg(8'h00, 8'h00);
    pulse(1, 0, 2'b01, 1); chk("R5 off match+force holds", a_val, 1);
    chk("R5 off enable low", a_en, 0);
  endtask

  task automatic t_pwm;
    set_cfg(8'h60, 8'h00);
    count_up = 1'b1;
    pulse(1, 0, 2'b00, 0); chk("R6 pwm clr up", a_val, 0);
    count_up = 1'b0;
    pulse(1, 0, 2'b00, 0); chk("R6 pwm clr down", a_val, 1);
    set_cfg(8'h70, 8'h00);
    pulse(1, 0, 2'b00, 0); chk("R6 pwm set down", a_val, 0);
    count_up = 1'b1;
    pulse(1, 0, 2'b00, 0); chk("R6 pwm set up", a_val, 1);
    set_cfg(8'h50, 8'h00);
    pulse(1, 0, 2'b00, 0); chk("R7 pwm toggle 1", a_val, 0);
    pulse(1, 0, 2'b00, 0); chk("R7 pwm toggle 2", a_val, 1);
  endtask

  task automatic t_force;
    set_cfg(8'h20, 8'h00);
    pulse(0, 0, 2'b01, 1); chk("R8 force A clear", a_val, 0);
    set_cfg(8'h30, 8'h00);
    pulse(0, 0, 2'b01, 0); chk("R11 force without write", a_val, 0);
    pulse(0, 0, 2'b01, 1); chk("R8 force A set", a_val, 1);
    set_cfg(8'h60, 8'h00);
    count_up = 1'b0;
    pulse(0, 0, 2'b01, 1); chk("R9 force ignored pwm", a_val, 1);
    count_up = 1'b1;
    set_cfg(8'h10, 8'h10);
    pulse(0, 0, 2'b10, 1); chk("R8 force B toggle", b_val, 0);
    chk("R12 A untouched by force B", a_val, 1);
    set_cfg(8'h10, 8'h50);
    pulse(0, 0, 2'b10, 1); chk("R9 force B ignored pwm", b_val, 0);
  endtask

  task automatic t_both;
    set_cfg(8'h10, 8'h00);
    pulse(1, 0, 2'b01, 1); chk("R10 match+force once 1", a_val, 0);
    pulse(1, 0, 2'b01, 1); chk("R10 match+force once 2", a_val, 1);
  endtask

  task automatic t_indep;
    set_cfg(8'h10, 8'h10);
    pulse(0, 1, 2'b00, 0); chk("R3 B toggle", b_val, 1);
    pulse(1, 0, 2'b00, 0);
    chk("R12 A toggled", a_val, 0);
    chk("R12 B held", b_val, 1);
  endtask

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_override();
    t_nonpwm();
    t_mode0();
    t_pwm();
    t_force();
    t_both();
    t_indep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule